// File: doc/BRIEF.md
# Segmented Oscillator Tuning Word Decoder

This block takes the frequency control word produced by a digital loop filter and turns it into the switch controls of a capacitor-bank oscillator split into several banks. A word is captured on the reference clock, crosses into a faster dither clock domain through a two-flop toggle synchronizer, and is then decoded there. The coarse field is a binary code that is registered twice, once for each tank winding. The mid-coarse and fine fields are expanded into thermometer codes, and the fine field saturates at the size of its bank.

The fractional bits below the fine field are not decoded directly. A sigma-delta modulator running on the dither clock turns them into a stream of unit counts for a three-unit extra bank. The modulator is either first order or a two-stage error-feedback cascade. The order is latched while the dither domain is held in reset. The modulator output is shifted up by one so that it is always a non-negative number of units.

Top module: `dco_tw_decoder`

## Requirements
- R1: The coarse field, word bits 18:15, appears as an unsigned binary value on `crs_pri`.
- R2: `crs_sec` always carries the same value as `crs_pri`.
- R3: A mid-coarse field value N (word bits 14:10) switches on bits 0 to N-1 of `mid_therm` and clears all the others.
- R4: `mid_therm` and `fine_therm` are always thermometer-shaped: the set bits form one contiguous run that starts at bit 0.
- R5: A fine field value N (word bits 9:4) switches on bits 0 to min(N,60)-1 of `fine_therm`, so the codes 61 to 63 give all 60 units.
- R6: A word presented with `tw_load` high at a rising `clk_ref` edge reaches the coarse, mid and fine outputs at the fourth rising `clk_dth` edge after that edge. Before that edge the outputs still show the previous word. A word presented with `tw_load` low changes nothing.
- R7: In first-order mode (`order_sel`=0 at reset) the dither bank shows one or two units (`dith_therm` 001 or 011). Over any 32 consecutive dither cycles the total unit count is exactly 32 + 2F, where F is the fraction, word bits 3:0.
- R8: In second-order mode (`order_sel`=1 at reset) `dith_therm` is one of 000, 001, 011 or 111, and the 32-cycle unit total stays within one of 32 + 2F. With fraction 5 applied from the reset state, some cycle shows zero or three units. With a zero fraction held from reset, exactly one unit is on in either mode.
- R9: `order_sel` is sampled only while `rst_dth_n` is low. A change while the block is running leaves the dither behaviour unchanged.
- R10: While held in reset, every output is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock on which tuning words are captured |
| rst_ref_n | input | 1 | Synchronous active-low reset for the reference domain |
| tw_load | input | 1 | Capture strobe for `tw_word` |
| tw_word | input | 19 | Tuning word: coarse, mid-coarse, fine and fraction fields |
| clk_dth | input | 1 | Dither clock, a quarter of the divided oscillator rate |
| rst_dth_n | input | 1 | Synchronous active-low reset for the dither domain |
| order_sel | input | 1 | Modulator order, 0 first, 1 second; latched during reset |
| crs_pri | output | 4 | Coarse binary code for the primary winding |
| crs_sec | output | 4 | Coarse binary code for the secondary winding |
| mid_therm | output | 31 | Mid-coarse thermometer code |
| fine_therm | output | 60 | Fine thermometer code |
| dith_therm | output | 3 | Dithered fractional unit bank, thermometer coded |

## Verification
The coarse, mid and fine outputs of a loaded word are due at the fourth dither edge after the reference edge that captured it. The scoreboard monitor pops each expected word at that reference edge and checks the outputs after the third dither edge, where the old word must still show. It then checks them again after the fourth edge, where the new word must show, sampling on falling dither edges. The dither bank has no fixed per-cycle value, so after a new fraction the bench waits four dither cycles for the modulator to run on it. It then checks the range and shape of each sample and the unit total over a 32-cycle window against the fraction.

// File: rtl/dtw_pkg.sv
// Shared types and constants of the oscillator tuning word decoder.
// Assumes: the dithered bank has three units in every configuration.
package dtw_pkg;

    // Order of the fractional sigma-delta modulator.
    typedef enum logic {
        SD_FIRST  = 1'b0,
        SD_SECOND = 1'b1
    } sd_order_e;

    // Units in the dithered fractional bank.
    localparam int DITH_UNITS = 3;

endpackage

// File: rtl/tw_cross.sv
// Moves a tuning word from the reference domain into the dither domain.
// The word is held in a source register and a toggle flag flips on each
// load. The flag passes two synchronizer flops; a third flop detects the
// edge and the held word is copied on the next dither edge.
// Assumes: the dither clock runs several times faster than the reference
// clock, so a held word is stable before it is copied.
module tw_cross #(
    parameter int W = 19
) (
    input  logic         clk_src_i,
    input  logic         rst_src_ni,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    input  logic         clk_dst_i,
    input  logic         rst_dst_ni,
    output logic [W-1:0] word_o,
    output logic         upd_o
);

    localparam int SYNC_D = 3;

    logic [W-1:0]      hold_q;
    logic              tog_q;
    logic [SYNC_D-1:0] sync_q;
    logic              new_w;

    // Hold the loaded word and flip the toggle flag on every load.
    always_ff @(posedge clk_src_i) begin
        if (!rst_src_ni) begin
            hold_q <= '0;
            tog_q  <= 1'b0;
        end else if (load_i) begin
            hold_q <= word_i;
            tog_q  <= ~tog_q;
        end
    end

    // Bring the toggle flag into the dither domain through two flops plus an edge flop.
    always_ff @(posedge clk_dst_i) begin
        if (!rst_dst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_D-2:0], tog_q};
        end
    end

    assign new_w = sync_q[SYNC_D-1] ^ sync_q[SYNC_D-2];

    // Copy the held word once per detected toggle edge.
    always_ff @(posedge clk_dst_i) begin
        if (!rst_dst_ni) begin
            word_o <= '0;
            upd_o  <= 1'b0;
        end else begin
            upd_o <= new_w;
            if (new_w) begin
                word_o <= hold_q;
            end
        end
    end

endmodule

// File: rtl/therm_enc.sv
// Registered binary-to-thermometer encoder with saturation.
// Output bit i is set when the input value is above i; inputs above UNITS
// give all UNITS bits set.
// Assumes: UNITS is at least 1.
module therm_enc #(
    parameter int IN_W  = 6,
    parameter int UNITS = 60
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [IN_W-1:0]  code_i,
    output logic [UNITS-1:0] therm_o
);

    localparam int CW = IN_W + $clog2(UNITS + 1);

    logic [CW-1:0]    code_w;
    logic [CW-1:0]    sat_w;
    logic [UNITS-1:0] therm_d;

    assign code_w = CW'(code_i);

    // Clamp the code to the bank size.
    always_comb begin
        sat_w = (code_w > CW'(UNITS)) ? CW'(UNITS) : code_w;
    end

    for (genvar g = 0; g < UNITS; g++) begin : g_bit
        assign therm_d[g] = (sat_w > CW'(g));
    end

    // Register the thermometer code.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            therm_o <= '0;
        end else begin
            therm_o <= therm_d;
        end
    end

    // R4: set bits form one run from bit 0
    a_r4_therm_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((therm_o + 1'b1) & therm_o) == '0);

    // R3 and R5: the unit count follows the previous code, clamped
    a_r5_unit_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ($countones(therm_o) ==
                  ((int'($past(code_i)) > UNITS) ? UNITS : int'($past(code_i)))));

endmodule

// File: rtl/sd_dither.sv
// Sigma-delta modulator for the fractional bits of the tuning word.
// First order: one accumulator whose carry is the output.
// Second order: two cascaded accumulators; output = c1 + c2 - c2 delayed.
// The output is shifted up by one and driven as a thermometer code.
// Assumes: the order input is constant outside reset.
module sd_dither
    import dtw_pkg::*;
#(
    parameter int FRAC_W = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  sd_order_e             order_i,
    input  logic [FRAC_W-1:0]     frac_i,
    output logic [DITH_UNITS-1:0] therm_o
);

    localparam int UW = $clog2(DITH_UNITS + 1);

    logic [FRAC_W-1:0]     acc1_q;
    logic [FRAC_W-1:0]     acc2_q;
    logic                  c2_q;
    logic [FRAC_W:0]       sum1;
    logic [FRAC_W:0]       sum2;
    logic                  c1;
    logic                  c2;
    logic [UW-1:0]         units_d;
    logic [DITH_UNITS-1:0] therm_d;

    assign sum1 = {1'b0, acc1_q} + {1'b0, frac_i};
    assign sum2 = {1'b0, acc2_q} + {1'b0, sum1[FRAC_W-1:0]};
    assign c1   = sum1[FRAC_W];
    assign c2   = (order_i == SD_SECOND) & sum2[FRAC_W];

    // Combine the stage carries and add the offset of one unit.
    always_comb begin
        units_d = UW'(1) + UW'(c1) + UW'(c2) - UW'(c2_q);
    end

    for (genvar g = 0; g < DITH_UNITS; g++) begin : g_unit
        assign therm_d[g] = (units_d > UW'(g));
    end

    // Advance the accumulators and register the unit bank.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            acc1_q  <= '0;
            acc2_q  <= '0;
            c2_q    <= 1'b0;
            therm_o <= '0;
        end else begin
            acc1_q  <= sum1[FRAC_W-1:0];
            acc2_q  <= (order_i == SD_SECOND) ? sum2[FRAC_W-1:0] : '0;
            c2_q    <= c2;
            therm_o <= therm_d;
        end
    end

    // R7: first order keeps one or two units on
    a_r7_first_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (order_i == SD_FIRST) |=> (therm_o == 3'b001 || therm_o == 3'b011));

    // R8: a zero fraction from a cleared second stage gives one unit
    a_r8_zero_frac: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frac_i == '0 && acc2_q == '0 && !c2_q) |=> (therm_o == 3'b001));

endmodule

// File: rtl/dco_tw_decoder.sv
// Oscillator tuning word decoder, top level.
// Word layout, LSB first: fraction, fine, mid-coarse, coarse.
// Captures the word on clk_ref, moves it to clk_dth and decodes it there:
// the coarse code is registered for two windings, the mid and fine codes
// become thermometer codes, and the fraction drives the dithered bank.
// Assumes: clk_dth is several times faster than clk_ref; order_sel is
// changed only while rst_dth_n is low.
module dco_tw_decoder
    import dtw_pkg::*;
#(
    parameter int CRS_W     = 4,
    parameter int MID_W     = 5,
    parameter int MID_UNITS = 31,
    parameter int FIN_W     = 6,
    parameter int FIN_UNITS = 60,
    parameter int FRAC_W    = 4
) (
    input  logic                                   clk_ref,
    input  logic                                   rst_ref_n,
    input  logic                                   tw_load,
    input  logic [CRS_W+MID_W+FIN_W+FRAC_W-1:0]    tw_word,
    input  logic                                   clk_dth,
    input  logic                                   rst_dth_n,
    input  logic                                   order_sel,
    output logic [CRS_W-1:0]                       crs_pri,
    output logic [CRS_W-1:0]                       crs_sec,
    output logic [MID_UNITS-1:0]                   mid_therm,
    output logic [FIN_UNITS-1:0]                   fine_therm,
    output logic [DITH_UNITS-1:0]                  dith_therm
);

    localparam int FIN_LSB  = FRAC_W;
    localparam int MID_LSB  = FIN_LSB + FIN_W;
    localparam int CRS_LSB  = MID_LSB + MID_W;
    localparam int TW_W     = CRS_LSB + CRS_W;
    localparam int WINDINGS = 2;

    logic [TW_W-1:0] word_act;
    logic            upd;
    sd_order_e       order_q;

    tw_cross #(
        .W (TW_W)
    ) u_cross (
        .clk_src_i  (clk_ref),
        .rst_src_ni (rst_ref_n),
        .load_i     (tw_load),
        .word_i     (tw_word),
        .clk_dst_i  (clk_dth),
        .rst_dst_ni (rst_dth_n),
        .word_o     (word_act),
        .upd_o      (upd)
    );

    // Latch the modulator order while the dither domain is in reset.
    always_ff @(posedge clk_dth) begin
        if (!rst_dth_n) begin
            order_q <= sd_order_e'(order_sel);
        end
    end

    // One coarse register per winding, both fed from the same field.
    for (genvar g = 0; g < WINDINGS; g++) begin : g_wind
        logic [CRS_W-1:0] crs_q;

        // Register the coarse field for this winding.
        always_ff @(posedge clk_dth) begin
            if (!rst_dth_n) begin
                crs_q <= '0;
            end else begin
                crs_q <= word_act[CRS_LSB +: CRS_W];
            end
        end

        if (g == 0) begin : g_pri
            assign crs_pri = crs_q;
        end else begin : g_sec
            assign crs_sec = crs_q;
        end
    end

    therm_enc #(
        .IN_W  (MID_W),
        .UNITS (MID_UNITS)
    ) u_mid (
        .clk_i   (clk_dth),
        .rst_ni  (rst_dth_n),
        .code_i  (word_act[MID_LSB +: MID_W]),
        .therm_o (mid_therm)
    );

    therm_enc #(
        .IN_W  (FIN_W),
        .UNITS (FIN_UNITS)
    ) u_fine (
        .clk_i   (clk_dth),
        .rst_ni  (rst_dth_n),
        .code_i  (word_act[FIN_LSB +: FIN_W]),
        .therm_o (fine_therm)
    );

    sd_dither #(
        .FRAC_W (FRAC_W)
    ) u_sd (
        .clk_i   (clk_dth),
        .rst_ni  (rst_dth_n),
        .order_i (order_q),
        .frac_i  (word_act[FRAC_W-1:0]),
        .therm_o (dith_therm)
    );

    // R6: static outputs move only on the cycle after a captured word
    a_r6_quiet: assert property (@(posedge clk_dth) disable iff (!rst_dth_n)
        !upd |=> ($stable(crs_pri) && $stable(mid_therm) && $stable(fine_therm)));

endmodule

// File: tb/test_dco_tw_decoder.sv
// Scoreboard bench: the load task queues each expected word, the monitor
// pops it at the capture edge and checks the outputs on the due cycle.
module test_dco_tw_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int REF_PERIOD = 8 * CLK_PERIOD;
    localparam int CRS_W      = 4;
    localparam int MID_W      = 5;
    localparam int MID_UNITS  = 31;
    localparam int FIN_W      = 6;
    localparam int FIN_UNITS  = 60;
    localparam int FRAC_W     = 4;
    localparam int FIN_LSB    = FRAC_W;
    localparam int MID_LSB    = FIN_LSB + FIN_W;
    localparam int CRS_LSB    = MID_LSB + MID_W;
    localparam int TW_W       = CRS_LSB + CRS_W;
    localparam int WIN        = 2 * (1 << FRAC_W);

    logic                 clk_dth   = 1'b0;
    logic                 clk_ref   = 1'b0;
    logic                 rst_ref_n = 1'b0;
    logic                 rst_dth_n = 1'b0;
    logic                 tw_load   = 1'b0;
    logic                 order_sel = 1'b0;
    logic [TW_W-1:0]      tw_word   = '0;
    logic [CRS_W-1:0]     crs_pri;
    logic [CRS_W-1:0]     crs_sec;
    logic [MID_UNITS-1:0] mid_therm;
    logic [FIN_UNITS-1:0] fine_therm;
    logic [2:0]           dith_therm;

    int              n_tests   = 0;
    int              n_fail    = 0;
    logic [TW_W-1:0] applied_w = '0;
    logic [TW_W-1:0] sb_q[$];
    bit              mon_busy  = 1'b0;
    bit              run_done  = 1'b0;

    dco_tw_decoder i_dco_tw_decoder (
        .clk_ref    (clk_ref),
        .rst_ref_n  (rst_ref_n),
        .tw_load    (tw_load),
        .tw_word    (tw_word),
        .clk_dth    (clk_dth),
        .rst_dth_n  (rst_dth_n),
        .order_sel  (order_sel),
        .crs_pri    (crs_pri),
        .crs_sec    (crs_sec),
        .mid_therm  (mid_therm),
        .fine_therm (fine_therm),
        .dith_therm (dith_therm)
    );

    always #(CLK_PERIOD / 2) clk_dth = ~clk_dth;

    initial begin
        #2;
        forever #(REF_PERIOD / 2) clk_ref = ~clk_ref;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    function automatic logic [TW_W-1:0] make_word(input int c, input int m, input int f, input int r);
        return {CRS_W'(c), MID_W'(m), FIN_W'(f), FRAC_W'(r)};
    endfunction

    function automatic logic [MID_UNITS-1:0] mid_exp(input logic [TW_W-1:0] w);
        int n = int'(w[MID_LSB +: MID_W]);
        logic [MID_UNITS-1:0] r = '0;
        if (n > MID_UNITS) n = MID_UNITS;
        for (int i = 0; i < MID_UNITS; i++) if (i < n) r[i] = 1'b1;
        return r;
    endfunction

    function automatic logic [FIN_UNITS-1:0] fine_exp(input logic [TW_W-1:0] w);
        int n = int'(w[FIN_LSB +: FIN_W]);
        logic [FIN_UNITS-1:0] r = '0;
        if (n > FIN_UNITS) n = FIN_UNITS;
        for (int i = 0; i < FIN_UNITS; i++) if (i < n) r[i] = 1'b1;
        return r;
    endfunction

    task automatic check_static(input logic [TW_W-1:0] w, input string tag);
        logic [CRS_W-1:0]     ce = w[CRS_LSB +: CRS_W];
        logic [MID_UNITS-1:0] me = mid_exp(w);
        logic [FIN_UNITS-1:0] fe = fine_exp(w);
        chk(crs_pri == ce, {tag, " R1 coarse primary"}, 64'(crs_pri), 64'(ce));
        chk(crs_sec == crs_pri, {tag, " R2 coarse mirror"}, 64'(crs_sec), 64'(crs_pri));
        chk(mid_therm == me, {tag, " R3 mid thermometer"}, 64'(mid_therm), 64'(me));
        chk(fine_therm == fe, {tag, " R5 fine thermometer"}, 64'(fine_therm), 64'(fe));
        chk((((mid_therm + 1'b1) & mid_therm) == '0) && (((fine_therm + 1'b1) & fine_therm) == '0),
            {tag, " R4 thermometer shape"}, 64'(fine_therm), 64'(fe));
    endtask

    // Monitor: pop the expected word at its capture edge and check old then new value.
    initial begin : monitor
        logic [TW_W-1:0] cur_w;
        forever begin
            wait (mon_busy);
            cur_w = sb_q.pop_front();
            repeat (3) @(posedge clk_dth);
            @(negedge clk_dth);
            check_static(applied_w, "R6 before due edge");
            @(posedge clk_dth);
            @(negedge clk_dth);
            check_static(cur_w, "R6 on due edge");
            applied_w = cur_w;
            mon_busy  = 1'b0;
        end
    end

    task automatic load_word(input logic [TW_W-1:0] w);
        @(negedge clk_ref);
        tw_word = w;
        tw_load = 1'b1;
        @(posedge clk_ref);
        sb_q.push_back(w);
        mon_busy = 1'b1;
        @(negedge clk_ref);
        tw_load = 1'b0;
        wait (!mon_busy);
    endtask

    task automatic idle_word(input logic [TW_W-1:0] w);
        @(negedge clk_ref);
        tw_word = w;
        tw_load = 1'b0;
        repeat (2) @(posedge clk_ref);
        @(negedge clk_dth);
        check_static(applied_w, "R6 load low ignored");
    endtask

    task automatic do_reset(input logic ord);
        order_sel = ord;
        tw_load   = 1'b0;
        tw_word   = '0;
        rst_ref_n = 1'b0;
        rst_dth_n = 1'b0;
        repeat (3) @(posedge clk_ref);
        @(negedge clk_dth);
        chk(crs_pri == '0 && crs_sec == '0, "R10 reset coarse", 64'(crs_pri), 64'd0);
        chk(mid_therm == '0, "R10 reset mid", 64'(mid_therm), 64'd0);
        chk(fine_therm == '0, "R10 reset fine", 64'(fine_therm), 64'd0);
        chk(dith_therm == '0, "R10 reset dither", 64'(dith_therm), 64'd0);
        @(negedge clk_ref);
        rst_ref_n = 1'b1;
        rst_dth_n = 1'b1;
        applied_w = '0;
    endtask

    task automatic dith_window(output int sum, output int n_ext, output int n_shape);
        sum     = 0;
        n_ext   = 0;
        n_shape = 0;
        repeat (4) @(posedge clk_dth);
        for (int i = 0; i < WIN; i++) begin
            int u;
            @(negedge clk_dth);
            u = $countones(dith_therm);
            sum += u;
            if (u == 0 || u == 3) n_ext++;
            if (!(dith_therm == 3'b000 || dith_therm == 3'b001 ||
                  dith_therm == 3'b011 || dith_therm == 3'b111)) n_shape++;
        end
    endtask

    task automatic check_first(input int frac, input string tag);
        int s, e, b;
        dith_window(s, e, b);
        chk(s == WIN + 2 * frac, {tag, " unit total"}, 64'(s), 64'(WIN + 2 * frac));
        chk(e == 0 && b == 0, {tag, " one or two units only"}, 64'(e), 64'd0);
    endtask

    task automatic check_second(input int frac, input bit need_ext);
        int s, e, b;
        dith_window(s, e, b);
        chk(s >= WIN + 2 * frac - 1 && s <= WIN + 2 * frac + 1, "R8 second order unit total",
            64'(s), 64'(WIN + 2 * frac));
        chk(b == 0, "R8 second order shape", 64'(b), 64'd0);
        if (need_ext) chk(e > 0, "R8 second order reaches 0 or 3 units", 64'(e), 64'd1);
    endtask

    initial begin : run
        int s, e, b;
        do_reset(1'b0);
        dith_window(s, e, b);
        chk(s == WIN && e == 0, "R8 zero fraction first order", 64'(s), 64'(WIN));
        load_word(make_word(15, 31, 60, 5));
        check_first(5, "R7 first order f5");
        load_word(make_word(9, 17, 63, 3));
        check_first(3, "R7 first order f3");
        idle_word(make_word(2, 2, 2, 2));
        load_word(make_word(3, 1, 61, 15));
        check_first(15, "R7 first order f15");
        load_word(make_word(0, 0, 1, 0));
        order_sel = 1'b1;
        load_word(make_word(10, 12, 33, 5));
        check_first(5, "R9 order change while running");
        do_reset(1'b1);
        dith_window(s, e, b);
        chk(s == WIN && e == 0, "R8 zero fraction second order", 64'(s), 64'(WIN));
        load_word(make_word(6, 30, 59, 5));
        check_second(5, 1'b1);
        load_word(make_word(12, 0, 20, 11));
        check_second(11, 1'b0);
        load_word(make_word(1, 31, 0, 15));
        check_second(15, 1'b0);
        run_done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk_dth);
        if (!run_done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R6 watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule